// File: doc/BRIEF.md
# Dual-Order Burst Word Address Generator

This block keeps the address register for a four-word burst access and produces the word address currently in use. A load pulse captures a full address. The bits above the lowest two pass straight through to `upperAddr`. The lowest two bits become the starting offset of a 2-bit wraparound counter. Each sampled advance moves the counter one step through the four-word group. The step order is either interleaved, where the offset is the start XOR the step count, or linear, where the offset is the start plus the step count, modulo four.

Two active-low load strobes feed the block. Either one, or both together, loads the address. The strobes are assumed to be already qualified by the access controller, which handles chip select and write control. The active-low advance input moves the counter. When advance is high, the offset is held, which suspends the burst. The order-select input is a static strap: low selects linear order and high selects interleaved order. It is only changed together with a load.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `upperAddr` and `wordOffset` to zero.
- R2: If either `loadProcN` or `loadCtrlN` is low at a rising edge, the block captures `addrIn`. Afterwards `upperAddr` equals `addrIn[ADDR_W-1:2]` and `wordOffset` equals `addrIn[1:0]`.
- R3: If both load strobes are low in the same cycle, the block loads exactly as it does for a single strobe.
- R4: If no load occurs and `stepN` is high at a rising edge, `wordOffset` and `upperAddr` keep their values (suspend).
- R5: With `orderSel` = 0 (linear), after n advances from start s, `wordOffset` = (s + n) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R6: With `orderSel` = 1 (interleaved), after n advances from start s, `wordOffset` = s XOR (n mod 4). For example, start 10 gives 10, 11, 00, 01.
- R7: The counter wraps inside the four-word group. It never changes `upperAddr`, and it keeps repeating the same four-offset pattern for more than four advances.
- R8: If a load and an advance are sampled in the same cycle, the advance is ignored. The offset right after that cycle is the loaded start offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | ADDR_W | Full access address |
| loadProcN | input | 1 | Qualified processor-side load strobe, active low |
| loadCtrlN | input | 1 | Qualified controller-side load strobe, active low |
| stepN | input | 1 | Advance to the next burst word, active low |
| orderSel | input | 1 | Static order strap: 1 interleaved, 0 linear |
| upperAddr | output | ADDR_W-2 | Registered address bits above the word offset |
| wordOffset | output | 2 | Current word offset within the burst |

## Verification
Two functions can land in the same cycle: a load of a new address and an advance of the running burst. The bench provokes this by driving `stepN` low while a load strobe is low, in the middle of a burst with a nonzero step count. The expected result is that the offset after that edge equals the new address's low bits, and that the next advance produces the second word of the new sequence. A second overlap occurs when the counter wraps from the last offset back to the first while the upper bits are all ones. There the bench confirms that `upperAddr` is unchanged.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int OFF_W = 2;

  typedef struct packed {
    logic load;
    logic step;
  } burstStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic          loadProcN,
  input  logic          loadCtrlN,
  input  logic          stepN,
  output burstStrobes_t strobes
);
  logic anyLoad;

  // Either qualified strobe loads; both together behave like one.
  assign anyLoad = ~loadProcN | ~loadCtrlN;

  always_comb begin
    strobes.load = anyLoad;
    // A load cycle takes priority; advance is dropped there.
    strobes.step = ~stepN & ~anyLoad;
  end
endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  burstStrobes_t     strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              orderSel,
  output logic [ADDR_W-OFF_W-1:0] upperAddr,
  output logic [OFF_W-1:0]  wordOffset
);
  localparam int UP_W = ADDR_W - OFF_W;

  logic [UP_W-1:0]  upperReg;
  logic [OFF_W-1:0] startReg;
  logic [OFF_W-1:0] stepCnt;
  logic [OFF_W-1:0] linearOff;
  logic [OFF_W-1:0] interOff;

  always_ff @(posedge clk) begin
    if (rst) begin
      upperReg <= '0;
      startReg <= '0;
      stepCnt  <= '0;
    end else if (strobes.load) begin
      upperReg <= addrIn[ADDR_W-1:OFF_W];
      startReg <= addrIn[OFF_W-1:0];
      stepCnt  <= '0;
    end else if (strobes.step) begin
      stepCnt  <= stepCnt + 1'b1;
    end
  end

  // Both orders derive from the start offset and the step count.
  assign linearOff = startReg + stepCnt;
  assign interOff  = startReg ^ stepCnt;

  assign upperAddr  = upperReg;
  assign wordOffset = orderSel ? interOff : linearOff;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              loadProcN,
  input  logic              loadCtrlN,
  input  logic              stepN,
  input  logic              orderSel,
  output logic [ADDR_W-3:0] upperAddr,
  output logic [1:0]        wordOffset
);
  burstStrobes_t strobes;

  burst_ctrl u_ctrl (
    .loadProcN (loadProcN),
    .loadCtrlN (loadCtrlN),
    .stepN     (stepN),
    .strobes   (strobes)
  );

  burst_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .addrIn     (addrIn),
    .orderSel   (orderSel),
    .upperAddr  (upperAddr),
    .wordOffset (wordOffset)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addrIn,
  input logic              loadProcN,
  input logic              loadCtrlN,
  input logic              stepN,
  input logic              orderSel,
  input logic [ADDR_W-3:0] upperAddr,
  input logic [1:0]        wordOffset
);
  logic ldSeen;
  assign ldSeen = ~loadProcN | ~loadCtrlN;

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (upperAddr == '0 && wordOffset == 2'd0));

  // R2, R3
  a_r2_upper_load: assert property (@(posedge clk) disable iff (rst)
    ldSeen |=> upperAddr == $past(addrIn[ADDR_W-1:2]));

  // R8
  a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
    ldSeen |=> wordOffset == $past(addrIn[1:0]));

  // R7
  a_r7_upper_stable: assert property (@(posedge clk) disable iff (rst)
    !ldSeen |=> $stable(upperAddr));

  // R4
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!ldSeen && stepN) ##1 $stable(orderSel) |-> $stable(wordOffset));

  // R5
  a_r5_linear_step: assert property (@(posedge clk) disable iff (rst)
    (!ldSeen && !stepN && !orderSel) ##1 !orderSel |->
      wordOffset == 2'($past(wordOffset) + 2'd1));

  // R6
  a_r6_inter_moves: assert property (@(posedge clk) disable iff (rst)
    (!ldSeen && !stepN && orderSel) ##1 orderSel |->
      $countones(wordOffset ^ $past(wordOffset)) != 0);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .addrIn     (addrIn),
  .loadProcN  (loadProcN),
  .loadCtrlN  (loadCtrlN),
  .stepN      (stepN),
  .orderSel   (orderSel),
  .upperAddr  (upperAddr),
  .wordOffset (wordOffset)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic          loadProcN = 1'b1;
  logic          loadCtrlN = 1'b1;
  logic          stepN = 1'b1;
  logic          orderSel = 1'b1;
  logic [AW-3:0] upperAddr;
  logic [1:0]    wordOffset;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  string curReq = "R1";

  int refUpper = 0;
  int refStart = 0;
  int refCnt = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .addrIn(addrIn), .loadProcN(loadProcN),
    .loadCtrlN(loadCtrlN), .stepN(stepN), .orderSel(orderSel),
    .upperAddr(upperAddr), .wordOffset(wordOffset)
  );

  // Behavioural reference, updated on each rising edge.
  always @(posedge clk) begin
    if (rst) begin
      refUpper = 0; refStart = 0; refCnt = 0;
    end else if (!loadProcN || !loadCtrlN) begin
      refUpper = int'(addrIn) / 4;
      refStart = int'(addrIn) % 4;
      refCnt = 0;
    end else if (!stepN) begin
      refCnt = refCnt + 1;
    end
  end

  function automatic int expOffset();
    if (orderSel) return refStart ^ (refCnt % 4);
    return (refStart + refCnt) % 4;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (int'(upperAddr) != refUpper || int'(wordOffset) != expOffset()) begin
        mismatched++;
        $display("FAIL %s: upper=%0h offset=%0d expected upper=%0h offset=%0d",
                 curReq, upperAddr, wordOffset, refUpper, expOffset());
      end
    end
  end

  task automatic idle(int n, bit adv);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      loadProcN = 1'b1; loadCtrlN = 1'b1; stepN = ~adv;
    end
  endtask

  // which: 0 processor strobe, 1 controller strobe, 2 both
  task automatic loadAddr(logic [AW-1:0] a, int which, bit sel, bit adv);
    @(negedge clk); #1;
    addrIn = a; orderSel = sel; stepN = ~adv;
    loadProcN = !(which == 0 || which == 2);
    loadCtrlN = !(which == 1 || which == 2);
  endtask

  initial begin
    curReq = "R1";
    idle(3, 1'b0);
    @(negedge clk); #1; rst = 1'b0;

    curReq = "R2";
    loadAddr(17'h1ABCD, 0, 1'b1, 1'b0);
    idle(2, 1'b0);
    loadAddr(17'h01236, 1, 1'b0, 1'b0);
    idle(2, 1'b0);

    curReq = "R3";
    loadAddr(17'h0F0F3, 2, 1'b1, 1'b0);
    idle(2, 1'b0);

    curReq = "R5";
    loadAddr(17'h05551, 0, 1'b0, 1'b0);
    idle(5, 1'b1);

    curReq = "R6";
    loadAddr(17'h0AAA2, 1, 1'b1, 1'b0);
    idle(6, 1'b1);

    curReq = "R4";
    idle(3, 1'b0);
    idle(1, 1'b1);
    idle(3, 1'b0);
    idle(2, 1'b1);

    curReq = "R8";
    loadAddr(17'h13573, 0, 1'b0, 1'b1);
    idle(1, 1'b0);
    idle(2, 1'b1);
    loadAddr(17'h02461, 1, 1'b1, 1'b1);
    idle(3, 1'b1);

    curReq = "R7";
    loadAddr(17'h1FFFF, 0, 1'b0, 1'b0);
    idle(9, 1'b1);
    loadAddr(17'h1FFFD, 1, 1'b1, 1'b0);
    idle(9, 1'b1);

    curReq = "R1";
    @(negedge clk); #1; rst = 1'b1;
    idle(2, 1'b1);
    @(negedge clk); #1; rst = 1'b0;
    idle(2, 1'b0);

    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule